// File: doc/BRIEF.md
# Condition-Flag and Branch Decision Unit

This unit keeps the processor's three sign flags (negative, zero, positive) and resolves conditional branches. It watches the register-write port. Whenever an instruction that writes a general register asserts `rf_we`, the unit classifies the 16-bit value on `rf_wdata` and updates the flags on that same clock edge. Loads, the operate instructions and address-load all write registers, so they all set the flags. Stores and branches never assert `rf_we`, so they leave the flags alone.

The flags live in a three-state machine. `CC_ZERO` is the reset state. The other two states are `CC_NEG` and `CC_POS`. When a write occurs, each state can move to any of the three (transitions `T_TO_NEG`, `T_TO_ZERO`, `T_TO_POS`). Without a write, every state takes `T_HOLD`. The NZP output is a one-hot decode of the state.

A branch presents the low 12 bits of its instruction together with the already-incremented PC. The decision is combinational and uses the current flags. So a branch in the same cycle as a register write sees the flags from before that write. The unit outputs the decision, the target address and the next PC.

Top module: `ccu_top`

## Requirements
- R1: While reset is active, and after it is released until the first write, `cc_nzp` is 3'b010 (bit 2 = N, bit 1 = Z, bit 0 = P).
- R2: `cc_nzp` has exactly one bit set in every cycle.
- R3: A write whose value has bit 15 set gives `cc_nzp` = 3'b100 from the next clock edge.
- R4: A write of value 0 gives `cc_nzp` = 3'b010 from the next clock edge.
- R5: A write of a nonzero value with bit 15 clear gives `cc_nzp` = 3'b001 from the next clock edge. This includes 16'h0001 and 16'h7FFF.
- R6: In a cycle with `rf_we` low, `cc_nzp` does not change, whatever the values of `rf_wdata` and the branch inputs.
- R7: `br_taken` = `br_valid` AND any bit of (`br_instr[11:9]` & `cc_nzp`). Instruction bit 11 selects N, bit 10 selects Z and bit 9 selects P.
- R8: A mask of 3'b000 is never taken. A mask of 3'b111 is always taken when `br_valid` is high.
- R9: `br_target` = `pc_inc` + sign-extended `br_instr[8:0]`, modulo 2^16.
- R10: `next_pc` equals `br_target` when `br_taken` is high, and equals `pc_inc` otherwise.
- R11: A branch in the same cycle as a register write is decided on the flags from before that write.
- R12: When `br_valid` is low, `br_taken` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rf_we | input | 1 | A flag-setting instruction writes a register this cycle |
| rf_wdata | input | 16 | Value being written to the register |
| br_valid | input | 1 | A conditional branch is being resolved this cycle |
| br_instr | input | 12 | Low instruction bits: [11:9] mask, [8:0] offset |
| pc_inc | input | 16 | PC already incremented past the branch |
| cc_nzp | output | 3 | Current flags {N,Z,P} |
| br_taken | output | 1 | Branch decision |
| br_target | output | 16 | Branch target address |
| next_pc | output | 16 | Address of the next instruction |

## Verification
The assertions assume that inputs are stable and defined around each rising edge, and that reset is asserted at start-up. They place no limit on how writes and branches combine. The scoreboard changes inputs only on falling edges. It runs every mask value against every flag state. It uses offsets at both extremes, including wrap-around past 16'hFFFF, and the sign boundary values 16'h7FFF and 16'h8000. It also holds a cycle where a write and a branch coincide, so that the decision on the old flags is exercised.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

    localparam int unsigned NZP_W = 3;

    typedef enum logic [1:0] {
        CC_ZERO = 2'd0,
        CC_NEG  = 2'd1,
        CC_POS  = 2'd2
    } cc_state_e;

    // Classify a written value into the next flag state.
    function automatic cc_state_e classify(input logic sign_bit, input logic is_zero);
        cc_state_e res;
        if (sign_bit)     res = CC_NEG;
        else if (is_zero) res = CC_ZERO;
        else              res = CC_POS;
        return res;
    endfunction

endpackage

// File: rtl/ccu_flag_fsm.sv
module ccu_flag_fsm
    import ccu_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_value,
    output logic [NZP_W-1:0]  nzp
);

    cc_state_e state_q;
    cc_state_e state_d;
    cc_state_e written;

    assign written = classify(wr_value[DATA_W-1], (wr_value == '0));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CC_ZERO;
        else        state_q <= state_d;
    end

    // Transitions: T_HOLD without a write, T_TO_NEG/T_TO_ZERO/T_TO_POS on a write
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CC_ZERO: if (wr_en) state_d = written;
            CC_NEG:  if (wr_en) state_d = written;
            CC_POS:  if (wr_en) state_d = written;
            default: state_d = CC_ZERO;
        endcase
    end

    // Outputs: one-hot {N,Z,P}
    always_comb begin
        unique case (state_q)
            CC_NEG:  nzp = 3'b100;
            CC_POS:  nzp = 3'b001;
            CC_ZERO: nzp = 3'b010;
            default: nzp = 3'b010;
        endcase
    end

endmodule

// File: rtl/ccu_branch_eval.sv
module ccu_branch_eval #(
    parameter int unsigned MASK_W = 3
) (
    input  logic              valid,
    input  logic [MASK_W-1:0] mask,
    input  logic [MASK_W-1:0] flags,
    output logic              taken
);

    logic [MASK_W-1:0] hit;

    for (genvar g = 0; g < MASK_W; g++) begin : g_hit
        assign hit[g] = mask[g] & flags[g];
    end

    assign taken = valid & (|hit);

endmodule

// File: rtl/ccu_target_add.sv
module ccu_target_add #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned OFF_W  = 9
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] target
);

    localparam int unsigned EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] offset_ext;

    assign offset_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
    assign target     = base + offset_ext;

endmodule

// File: rtl/ccu_top.sv
module ccu_top
    import ccu_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned OFF_W  = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rf_we,
    input  logic [DATA_W-1:0]       rf_wdata,
    input  logic                    br_valid,
    input  logic [OFF_W+NZP_W-1:0]  br_instr,
    input  logic [ADDR_W-1:0]       pc_inc,
    output logic [NZP_W-1:0]        cc_nzp,
    output logic                    br_taken,
    output logic [ADDR_W-1:0]       br_target,
    output logic [ADDR_W-1:0]       next_pc
);

    localparam int unsigned MASK_LSB = OFF_W;
    localparam int unsigned MASK_MSB = OFF_W + NZP_W - 1;

    logic [NZP_W-1:0] mask;
    logic [OFF_W-1:0] offset;

    assign mask   = br_instr[MASK_MSB:MASK_LSB];
    assign offset = br_instr[OFF_W-1:0];

    ccu_flag_fsm #(.DATA_W(DATA_W)) i_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (rf_we),
        .wr_value (rf_wdata),
        .nzp      (cc_nzp)
    );

    ccu_branch_eval #(.MASK_W(NZP_W)) i_eval (
        .valid (br_valid),
        .mask  (mask),
        .flags (cc_nzp),
        .taken (br_taken)
    );

    ccu_target_add #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_add (
        .base   (pc_inc),
        .offset (offset),
        .target (br_target)
    );

    assign next_pc = br_taken ? br_target : pc_inc;

endmodule

// File: rtl/ccu_checker.sv
module ccu_checker #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned OFF_W  = 9
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rf_we,
    input logic [DATA_W-1:0]   rf_wdata,
    input logic                br_valid,
    input logic [OFF_W+2:0]    br_instr,
    input logic [ADDR_W-1:0]   pc_inc,
    input logic [2:0]          cc_nzp,
    input logic                br_taken,
    input logic [ADDR_W-1:0]   br_target,
    input logic [ADDR_W-1:0]   next_pc
);

    assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(cc_nzp));

    assert_neg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we && rf_wdata[DATA_W-1] |=> cc_nzp == 3'b100);

    assert_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we && rf_wdata == '0 |=> cc_nzp == 3'b010);

    assert_pos_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we && !rf_wdata[DATA_W-1] && rf_wdata != '0 |=> cc_nzp == 3'b001);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rf_we |=> $stable(cc_nzp));

    assert_mask_none_R8: assert property (@(posedge clk) disable iff (!rst_n)
        br_instr[OFF_W+2:OFF_W] == 3'b000 |-> !br_taken);

    assert_mask_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid && br_instr[OFF_W+2:OFF_W] == 3'b111 |-> br_taken);

    assert_fallthru_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !br_taken |-> next_pc == pc_inc);

    assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid |-> !br_taken);

endmodule

bind ccu_top ccu_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_ccu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .rf_we     (rf_we),
    .rf_wdata  (rf_wdata),
    .br_valid  (br_valid),
    .br_instr  (br_instr),
    .pc_inc    (pc_inc),
    .cc_nzp    (cc_nzp),
    .br_taken  (br_taken),
    .br_target (br_target),
    .next_pc   (next_pc)
);

// File: tb/test_ccu_top.sv
`timescale 1ns/1ps
module test_ccu_top;

    localparam time CLK_HALF = 4ns;

    typedef struct {
        logic        taken;
        logic [15:0] target;
        logic [15:0] nxt;
        logic [2:0]  nzp;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rf_we = 1'b0;
    logic [15:0] rf_wdata = '0;
    logic        br_valid = 1'b0;
    logic [11:0] br_instr = '0;
    logic [15:0] pc_inc = '0;
    logic [2:0]  cc_nzp;
    logic        br_taken;
    logic [15:0] br_target;
    logic [15:0] next_pc;

    exp_t        sb_q[$];
    logic [2:0]  model_nzp = 3'b010;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 0;

    always #CLK_HALF clk = ~clk;

    ccu_top i_ccu_top (
        .clk(clk), .rst_n(rst_n), .rf_we(rf_we), .rf_wdata(rf_wdata),
        .br_valid(br_valid), .br_instr(br_instr), .pc_inc(pc_inc),
        .cc_nzp(cc_nzp), .br_taken(br_taken), .br_target(br_target), .next_pc(next_pc)
    );

    function automatic logic [2:0] nzp_of(input logic [15:0] v);
        if (v[15])      return 3'b100;
        if (v == 16'd0) return 3'b010;
        return 3'b001;
    endfunction

    // Driver: drives one cycle on the falling edge and pushes the expectation
    task automatic drive(input logic we, input logic [15:0] wd, input logic bv,
                         input logic [2:0] mask, input logic [8:0] off,
                         input logic [15:0] pc, input string req);
        exp_t e;
        @(negedge clk);
        rf_we = we; rf_wdata = wd; br_valid = bv;
        br_instr = {mask, off}; pc_inc = pc;
        e.nzp    = model_nzp;
        e.taken  = bv && ((mask & model_nzp) != 3'b000);
        e.target = pc + {{7{off[8]}}, off};
        e.nxt    = e.taken ? e.target : pc;
        e.req    = req;
        sb_q.push_back(e);
        if (we) model_nzp = nzp_of(wd);
    endtask

    // Monitor: compares outputs between edges
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_cmp++;
                if (cc_nzp !== e.nzp || br_taken !== e.taken ||
                    br_target !== e.target || next_pc !== e.nxt) begin
                    n_bad++;
                    $display("FAIL %s: nzp=%b taken=%b target=%h next=%h expected nzp=%b taken=%b target=%h next=%h",
                             e.req, cc_nzp, br_taken, br_target, next_pc,
                             e.nzp, e.taken, e.target, e.nxt);
                end
            end
        end
    end

    initial begin
        #(CLK_HALF * 2 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset value while reset is held
        #3;
        n_cmp++;
        if (cc_nzp !== 3'b010) begin
            n_bad++;
            $display("FAIL R1: nzp=%b expected 010", cc_nzp);
        end
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R1: flags after release, idle branch R12
        drive(0, 16'h1234, 0, 3'b111, 9'h000, 16'h3000, "R1");
        // R8: all-ones mask taken on Z, R9 positive offset
        drive(0, 16'h0, 1, 3'b111, 9'h005, 16'h3001, "R8");
        // R8: empty mask never taken
        drive(0, 16'h0, 1, 3'b000, 9'h005, 16'h3001, "R8");
        // R3: negative write
        drive(1, 16'h8000, 0, 3'b000, 9'h000, 16'h3002, "R3");
        // R7: each mask bit against N
        for (int m = 0; m < 8; m++) drive(0, 16'h0, 1, 3'(m), 9'h1FF, 16'h3010, "R7");
        // R5: positive boundary 7FFF
        drive(1, 16'h7FFF, 0, 3'b000, 9'h000, 16'h3020, "R5");
        for (int m = 0; m < 8; m++) drive(0, 16'h0, 1, 3'(m), 9'h100, 16'h3030, "R7");
        // R4: zero write
        drive(1, 16'h0000, 0, 3'b000, 9'h000, 16'h3040, "R4");
        for (int m = 0; m < 8; m++) drive(0, 16'h0, 1, 3'(m), 9'h0FF, 16'h3050, "R7");
        // R5: smallest positive
        drive(1, 16'h0001, 0, 3'b000, 9'h000, 16'h3060, "R5");
        // R6: no write, noisy data and branch inputs
        drive(0, 16'hFFFF, 1, 3'b100, 9'h0AA, 16'h3070, "R6");
        drive(0, 16'h0000, 0, 3'b010, 9'h055, 16'h3071, "R6");
        drive(0, 16'h0000, 1, 3'b001, 9'h003, 16'h3072, "R6");
        // R11: write negative and branch on P in same cycle, then branch on P again
        drive(1, 16'hFFFE, 1, 3'b001, 9'h010, 16'h4000, "R11");
        drive(0, 16'h0, 1, 3'b001, 9'h010, 16'h4001, "R11");
        // R9: wrap-around high and low
        drive(0, 16'h0, 1, 3'b100, 9'h0FF, 16'hFFF0, "R9");
        drive(0, 16'h0, 1, 3'b100, 9'h100, 16'h0010, "R9");
        // R10: not taken keeps sequential PC
        drive(0, 16'h0, 1, 3'b011, 9'h0FF, 16'h5555, "R10");
        // R12: valid low with full mask
        drive(0, 16'h0, 0, 3'b111, 9'h0FF, 16'h6000, "R12");
        // R2: sequence of writes keeps one-hot
        drive(1, 16'h0000, 0, 3'b000, 9'h0, 16'h0, "R2");
        drive(1, 16'h4000, 0, 3'b000, 9'h0, 16'h0, "R2");
        drive(1, 16'hC000, 0, 3'b000, 9'h0, 16'h0, "R2");
        drive(0, 16'h0, 0, 3'b000, 9'h0, 16'h0, "R2");
        @(negedge clk);
        #4;
        n_cmp++;
        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL R2: %0d items left, expected 0", sb_q.size());
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule